// File: doc/BRIEF.md
# Indexed Performance Counter Unit

The unit holds a bank of event counters that software reaches through a small word-addressed register bus. Each counter is bound to one event condition, chosen by number from a vector of condition inputs. On every clock cycle in which the global run bit is set and its chosen condition is high, the counter adds one. Condition number 0 never fires. A counter is therefore stopped by binding it to condition 0. There is no separate enable for each counter.

Access to each counter is indirect. A selector register names one counter. The binding register, the two count halves and the snapshot request then all act on that counter. A snapshot copies the full counter into a shared pair of snapshot words in a single cycle. Software can then read the two halves without a carry tearing the value. Two build words report the bank size, the counter width and the number of conditions. A second selector returns a printable eight-character name for each condition. Overflow raises no interrupt: counters wrap without notice.

Top module: `pcu_top`

## Requirements
- R1: The selector register (address 1) picks the counter that the binding (2), count-low (3), count-high (4) and snapshot operations act on. Binding and count writes reach only the selected counter.
- R2: Control register (address 0) bit 0 is the global run bit and resets to 0. While it is 0, no counter changes except through a count write.
- R3: Writes use two halfword strobes: be[0] enables bits 15:0 and be[1] enables bits 31:16. Control bits 31:16 form a 16-bit tag that a write with only be[0] set leaves unchanged.
- R4: Writing control with be[0] set and bit 1 high copies the selected counter into snapshot-low (5) and snapshot-high (6) in the same edge. Bit 1 reads back as 0. If the counter increments on that same edge, the pre-increment value is captured.
- R5: The binding register holds a condition number. A counter increments by exactly one per cycle with run = 1 and its bound condition input high. Condition 0 never counts, whatever the level of cond_i[0].
- R6: Count-low and count-high are writable. A count write takes precedence over an increment on the same edge, and that increment is dropped.
- R7: A counter is 32 + 16*SIZE_SEL bits wide. Count-high returns the upper bits zero-extended. The counter wraps modulo its width, and a carry propagates from low to high.
- R8: The build word (address 7) reads bit 0 = 1, bits 15:8 = number of counters and bits 19:16 = SIZE_SEL. The default parameters give 0x00010401.
- R9: The condition build word (address 8) reads bit 0 = 1 and bits 15:8 = number of conditions (default 0x00000801). The condition selector (9) picks a name, returned in two words (10, 11), with the first character in bits 7:0 of word 10. Condition 0 is named "never   ". Condition k is named "evt_" followed by four uppercase hex digits of k. A selector at or above the condition count returns zeros.
- R10: With the selector at or above the number of counters, binding and count registers read 0 and ignore writes, and a snapshot captures 0.
- R11: Read data and bus_rvalid appear on the clock edge after a read request and are held for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | NUM_COND | Event condition inputs; bit 0 is ignored |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_be | input | 2 | Halfword write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |

## Verification
Register writes take effect on the edge that samples the request. Read data is due one edge after its request, and a scoreboard monitor samples it at the following falling edge. Each expected word is pushed into a queue when its read is issued, so every result is compared in exactly the cycle it is due. A counter moves on each edge where run was already set and the bound condition input is high. The bench therefore holds a condition high for an exact number of falling-to-falling intervals and expects exactly that count. The same-edge cases (snapshot with increment, count write with increment) drive the condition and the bus request in the same half cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [3:0] {
        A_CTRL   = 4'd0,
        A_SEL    = 4'd1,
        A_EVCFG  = 4'd2,
        A_CNTLO  = 4'd3,
        A_CNTHI  = 4'd4,
        A_SNPLO  = 4'd5,
        A_SNPHI  = 4'd6,
        A_BUILD  = 4'd7,
        A_CBUILD = 4'd8,
        A_CSEL   = 4'd9,
        A_NAME0  = 4'd10,
        A_NAME1  = 4'd11
    } pcu_addr_e;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_SNAP_BIT = 1;

    function automatic logic [7:0] hex_char(input logic [3:0] nib);
        if (nib < 4'd10) hex_char = 8'h30 + {4'd0, nib};
        else             hex_char = 8'h41 + {4'd0, nib} - 8'd10;
    endfunction

endpackage

// File: rtl/pcu_counter.sv
module pcu_counter #(
    parameter int CNTW     = 48,
    parameter int NUM_COND = 8,
    parameter int CONDW    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic [NUM_COND-1:0] cond_i,
    input  logic                cfg_we_i,
    input  logic [CONDW-1:0]    cfg_i,
    input  logic                lo_we_i,
    input  logic                hi_we_i,
    input  logic [31:0]         wmask_i,
    input  logic [31:0]         wdata_i,
    output logic [CONDW-1:0]    cfg_o,
    output logic [CNTW-1:0]     cnt_o
);
    localparam int HIW   = CNTW - 32;
    localparam int CPADW = 1 << CONDW;

    typedef struct packed {
        logic [CONDW-1:0] cfg;
        logic [CNTW-1:0]  cnt;
    } cstate_t;

    cstate_t             st_d, st_q;
    logic [CPADW-1:0]    cond_pad;
    logic                hit;

    always_comb begin
        cond_pad                 = '0;
        cond_pad[NUM_COND-1:0]   = cond_i;
        cond_pad[0]              = 1'b0;    // condition 0 never fires
        hit                      = run_i && cond_pad[st_q.cfg];

        st_d = st_q;
        if (cfg_we_i) st_d.cfg = cfg_i;
        if (lo_we_i) begin
            st_d.cnt[31:0] = (st_q.cnt[31:0] & ~wmask_i) | (wdata_i & wmask_i);
        end else if (hi_we_i) begin
            st_d.cnt[CNTW-1:32] = (st_q.cnt[CNTW-1:32] & ~wmask_i[HIW-1:0])
                                | (wdata_i[HIW-1:0] & wmask_i[HIW-1:0]);
        end else if (hit) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;
    assign cnt_o = st_q.cnt;

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !lo_we_i && !hi_we_i) |=> $stable(cnt_o)); // R2
    AST_NEVER_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o == '0 && !lo_we_i && !hi_we_i) |=> $stable(cnt_o)); // R5
    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_we_i && !hi_we_i) |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1)); // R7

endmodule

// File: rtl/pcu_cond_name.sv
module pcu_cond_name
    import pcu_pkg::*;
#(
    parameter int NUM_COND = 8
) (
    input  logic [7:0]  csel_i,
    output logic [31:0] name0_o,
    output logic [31:0] name1_o
);
    always_comb begin
        if (csel_i >= 8'(NUM_COND)) begin
            name0_o = '0;
            name1_o = '0;
        end else if (csel_i == 8'd0) begin
            // "never   " with first character in the low byte
            name0_o = {8'h65, 8'h76, 8'h65, 8'h6E};
            name1_o = {8'h20, 8'h20, 8'h20, 8'h72};
        end else begin
            // "evt_" then four hex digits, most significant first
            name0_o = {8'h5F, 8'h74, 8'h76, 8'h65};
            name1_o = {hex_char(csel_i[3:0]), hex_char(csel_i[7:4]), 8'h30, 8'h30};
        end
    end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
#(
    parameter int NUM_CNT  = 4,
    parameter int SIZE_SEL = 1,
    parameter int NUM_COND = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COND-1:0] cond_i,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [3:0]          bus_addr,
    input  logic [1:0]          bus_be,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid
);
    localparam int CNTW  = 32 + 16 * SIZE_SEL;
    localparam int HIW   = CNTW - 32;
    localparam int CONDW = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;
    localparam int IDXC  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
    localparam int NPAD  = 1 << IDXC;
    localparam int IDXW  = 8;

    typedef struct packed {
        logic            run;
        logic [15:0]     tag;
        logic [IDXW-1:0] sel;
        logic [7:0]      csel;
        logic [31:0]     snap_lo;
        logic [31:0]     snap_hi;
        logic [31:0]     rdata;
        logic            rvalid;
    } tstate_t;

    tstate_t st_d, st_q;

    pcu_addr_e        addr;
    logic             wr, rd, sel_ok;
    logic [31:0]      wmask;
    logic [IDXC-1:0]  sel_idx;
    logic [CNTW-1:0]  cnt_pad [NPAD];
    logic [CONDW-1:0] cfg_pad [NPAD];
    logic [CNTW-1:0]  cur_cnt;
    logic [CONDW-1:0] cur_cfg;
    logic [31:0]      name0, name1;

    assign addr    = pcu_addr_e'(bus_addr);
    assign wr      = bus_req && bus_we;
    assign rd      = bus_req && !bus_we;
    assign wmask   = {{16{bus_be[1]}}, {16{bus_be[0]}}};
    assign sel_ok  = st_q.sel < IDXW'(NUM_CNT);
    assign sel_idx = st_q.sel[IDXC-1:0];
    assign cur_cnt = sel_ok ? cnt_pad[sel_idx] : '0;
    assign cur_cfg = sel_ok ? cfg_pad[sel_idx] : '0;

    for (genvar i = 0; i < NPAD; i++) begin : g_cnt
        if (i < NUM_CNT) begin : g_live
            logic hit_sel;
            assign hit_sel = wr && sel_ok && (sel_idx == IDXC'(i));
            pcu_counter #(
                .CNTW    (CNTW),
                .NUM_COND(NUM_COND),
                .CONDW   (CONDW)
            ) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .run_i   (st_q.run),
                .cond_i  (cond_i),
                .cfg_we_i(hit_sel && addr == A_EVCFG && bus_be[0]),
                .cfg_i   (bus_wdata[CONDW-1:0]),
                .lo_we_i (hit_sel && addr == A_CNTLO),
                .hi_we_i (hit_sel && addr == A_CNTHI),
                .wmask_i (wmask),
                .wdata_i (bus_wdata),
                .cfg_o   (cfg_pad[i]),
                .cnt_o   (cnt_pad[i])
            );
        end else begin : g_pad
            assign cnt_pad[i] = '0;
            assign cfg_pad[i] = '0;
        end
    end

    pcu_cond_name #(.NUM_COND(NUM_COND)) u_name (
        .csel_i (st_q.csel),
        .name0_o(name0),
        .name1_o(name1)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd;
        st_d.rdata  = '0;

        if (wr) begin
            unique case (addr)
                A_CTRL: begin
                    if (bus_be[0]) begin
                        st_d.run = bus_wdata[CTRL_RUN_BIT];
                        if (bus_wdata[CTRL_SNAP_BIT]) begin
                            st_d.snap_lo = cur_cnt[31:0];
                            st_d.snap_hi = 32'(cur_cnt[CNTW-1:32]);
                        end
                    end
                    if (bus_be[1]) st_d.tag = bus_wdata[31:16];
                end
                A_SEL:  if (bus_be[0]) st_d.sel  = bus_wdata[IDXW-1:0];
                A_CSEL: if (bus_be[0]) st_d.csel = bus_wdata[7:0];
                default: ;
            endcase
        end

        if (rd) begin
            unique case (addr)
                A_CTRL:   st_d.rdata = {st_q.tag, 15'd0, st_q.run};
                A_SEL:    st_d.rdata = 32'(st_q.sel);
                A_EVCFG:  st_d.rdata = 32'(cur_cfg);
                A_CNTLO:  st_d.rdata = cur_cnt[31:0];
                A_CNTHI:  st_d.rdata = 32'(cur_cnt[CNTW-1:32]);
                A_SNPLO:  st_d.rdata = st_q.snap_lo;
                A_SNPHI:  st_d.rdata = st_q.snap_hi;
                A_BUILD:  st_d.rdata = {12'd0, 4'(SIZE_SEL), 8'(NUM_CNT), 7'd0, 1'b1};
                A_CBUILD: st_d.rdata = {16'd0, 8'(NUM_COND), 7'd0, 1'b1};
                A_CSEL:   st_d.rdata = {24'd0, st_q.csel};
                A_NAME0:  st_d.rdata = name0;
                A_NAME1:  st_d.rdata = name1;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid); // R11
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid); // R11
    AST_SNAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == A_CTRL) |=> !bus_rdata[CTRL_SNAP_BIT]); // R4
    AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !sel_ok &&
         (bus_addr == A_EVCFG || bus_addr == A_CNTLO || bus_addr == A_CNTHI))
        |=> bus_rdata == 32'd0); // R10
    AST_HI_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == A_CNTHI) |=> (bus_rdata >> HIW) == 32'd0); // R7

endmodule

// File: tb/tb_pcu_top.sv
module tb_pcu_top;
    import pcu_pkg::*;

    localparam int NUM_COND = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NUM_COND-1:0] cond_i = '0;
    logic                bus_req = 1'b0;
    logic                bus_we = 1'b0;
    logic [3:0]          bus_addr = '0;
    logic [1:0]          bus_be = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic                bus_rvalid;

    always #2 clk = ~clk;   // 250 MHz

    pcu_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_i    (cond_i),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    n_cmp  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    // Monitor: read data is due at the falling edge after the request's edge (R11)
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_fail++;
                $display("FAIL R11 unexpected rvalid: actual %08h expected no data", bus_rdata);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                n_cmp++;
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %08h expected %08h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic bus_wr(input pcu_addr_e a, input logic [31:0] d, input logic [1:0] be);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input pcu_addr_e a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic pulse(input logic [NUM_COND-1:0] c, input int k);
        cond_i = c;
        repeat (k) @(negedge clk);
        cond_i = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state and build words
        bus_rd(A_CTRL,   32'h0000_0000, "R2 reset control");
        bus_rd(A_BUILD,  32'h0001_0401, "R8 build word");
        bus_rd(A_CBUILD, 32'h0000_0801, "R9 condition build word");

        // Condition names
        bus_wr(A_CSEL, 32'd0, 2'b01);
        bus_rd(A_NAME0, 32'h6576_656E, "R9 name0 cond 0");
        bus_rd(A_NAME1, 32'h2020_2072, "R9 name1 cond 0");
        bus_wr(A_CSEL, 32'd5, 2'b01);
        bus_rd(A_NAME0, 32'h5F74_7665, "R9 name0 cond 5");
        bus_rd(A_NAME1, 32'h3530_3030, "R9 name1 cond 5");
        bus_wr(A_CSEL, 32'd8, 2'b01);
        bus_rd(A_NAME0, 32'h0000_0000, "R9 name0 out of range");

        // Bind counters 0,1,2 to conditions 2,3,0
        bus_wr(A_SEL, 32'd0, 2'b01); bus_wr(A_EVCFG, 32'd2, 2'b01);
        bus_wr(A_SEL, 32'd1, 2'b01); bus_wr(A_EVCFG, 32'd3, 2'b01);
        bus_wr(A_SEL, 32'd2, 2'b01); bus_wr(A_EVCFG, 32'd0, 2'b01);
        bus_wr(A_CTRL, 32'h1, 2'b11);
        pulse(8'b0000_0101, 5);
        pulse(8'b0000_1001, 3);
        bus_wr(A_SEL, 32'd0, 2'b01);
        bus_rd(A_CNTLO, 32'd5, "R5 counter0 counts cond 2");
        bus_rd(A_CNTHI, 32'd0, "R7 counter0 high");
        bus_wr(A_SEL, 32'd1, 2'b01);
        bus_rd(A_CNTLO, 32'd3, "R1 counter1 counts cond 3");
        bus_rd(A_EVCFG, 32'd3, "R1 counter1 binding");
        bus_wr(A_SEL, 32'd2, 2'b01);
        bus_rd(A_CNTLO, 32'd0, "R5 condition 0 never counts");

        // Freeze
        bus_wr(A_CTRL, 32'h0, 2'b01);
        pulse(8'b0000_0100, 4);
        bus_wr(A_SEL, 32'd0, 2'b01);
        bus_rd(A_CNTLO, 32'd5, "R2 run=0 freezes");

        // Tag halfword
        bus_wr(A_CTRL, 32'hABCD_0000, 2'b10);
        bus_rd(A_CTRL, 32'hABCD_0000, "R3 tag write");
        bus_wr(A_CTRL, 32'hFFFF_0001, 2'b01);
        bus_rd(A_CTRL, 32'hABCD_0001, "R3 low-half write keeps tag");

        // Wrap and carry on counter 0 (run = 1)
        bus_wr(A_CNTLO, 32'hFFFF_FFFE, 2'b11);
        bus_wr(A_CNTHI, 32'h0000_FFFF, 2'b11);
        pulse(8'b0000_0100, 3);
        bus_rd(A_CNTLO, 32'd1, "R7 wrap low");
        bus_rd(A_CNTHI, 32'd0, "R7 wrap high");
        bus_wr(A_CNTLO, 32'hFFFF_FFFF, 2'b11);
        pulse(8'b0000_0100, 1);
        bus_rd(A_CNTLO, 32'd0, "R7 carry low");
        bus_rd(A_CNTHI, 32'd1, "R7 carry high");

        // Snapshot of counter 1
        bus_wr(A_SEL, 32'd1, 2'b01);
        bus_wr(A_CTRL, 32'h3, 2'b01);
        bus_rd(A_SNPLO, 32'd3, "R4 snapshot low");
        bus_rd(A_SNPHI, 32'd0, "R4 snapshot high");
        bus_rd(A_CTRL, 32'hABCD_0001, "R4 snap bit reads 0");
        cond_i = 8'b0000_1000;
        bus_wr(A_CTRL, 32'h3, 2'b01);
        cond_i = '0;
        bus_rd(A_SNPLO, 32'd3, "R4 snapshot takes pre-increment value");
        bus_rd(A_CNTLO, 32'd4, "R4 counter still increments");

        // Count write beats increment
        cond_i = 8'b0000_1000;
        bus_wr(A_CNTLO, 32'h100, 2'b11);
        cond_i = '0;
        bus_rd(A_CNTLO, 32'h100, "R6 write wins over increment");
        bus_wr(A_CNTHI, 32'h1234, 2'b01);
        bus_rd(A_CNTHI, 32'h1234, "R6 high half writable");

        // Out-of-range selector
        bus_wr(A_SEL, 32'd7, 2'b01);
        bus_wr(A_CNTLO, 32'h55, 2'b11);
        bus_wr(A_EVCFG, 32'd2, 2'b01);
        bus_rd(A_CNTLO, 32'd0, "R10 count reads 0");
        bus_rd(A_EVCFG, 32'd0, "R10 binding reads 0");
        bus_wr(A_CTRL, 32'h3, 2'b01);
        bus_rd(A_SNPLO, 32'd0, "R10 snapshot captures 0");
        bus_wr(A_SEL, 32'd3, 2'b01);
        bus_rd(A_CNTLO, 32'd0, "R10 counter3 untouched");
        bus_rd(A_EVCFG, 32'd0, "R10 counter3 binding untouched");
        bus_wr(A_SEL, 32'd0, 2'b01);
        bus_rd(A_CNTHI, 32'd1, "R1 counter0 unaffected by others");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_fail++;
            $display("FAIL R11 missing read data: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        summary();
    end
endmodule